// File: doc/BRIEF.md
# T1 Receive Error Performance Counters

This block keeps the receive-side error tallies of a T1 framer. It takes single-cycle event strobes from the line decoder and the framer. These are line code violations, CRC6 errors, terminal-framing (Ft) bit errors, signaling-framing (Fs) bit errors, framing-pattern (FPS) bit errors and multiframe boundaries. The current framing mode and two select bits decide which strobes reach which counter.

There are three counters: a line counter, a path counter and an out-of-sync counter. All of them count without pause and saturate at all ones. On each one-second tick, every counter hands its value to a holding register that a host can read, and then starts again from zero. The holding registers change only on the tick, so a host can read them at any time during the following second.

Top module: `t1_perf_counters`

## Requirements
- R1: After reset, all holding outputs read zero, and the first tick also transfers zero for every counter.
- R2: The line counter is 16 bits wide and adds one for each `lcv_evt` strobe, whatever the mode or sync state. Its held value is presented as `lcv_hold_hi` (bits 15:8) and `lcv_hold_lo` (bits 7:0).
- R3: With `esf_mode`=1, the path counter adds one for each `crc_err_evt` strobe and ignores the Ft, Fs and FPS strobes.
- R4: With `esf_mode`=0, the path counter adds one per `ft_err_evt`. When `fs_incl`=1 it also adds one per `fs_err_evt`, and a cycle with both strobes adds one. CRC strobes are ignored.
- R5: While `rx_los`=1, the path counter does not change, apart from the clear on a tick.
- R6: With `oos_sel`=0, the out-of-sync counter counts framing-bit errors. In ESF mode that is `fps_err_evt`. In SF mode it is `ft_err_evt`, plus `fs_err_evt` when `fs_incl`=1. This counting is not gated by `rx_los`.
- R7: With `oos_sel`=1, the out-of-sync counter adds one for each `mf_evt` strobe that arrives while `rx_los`=1. It ignores `mf_evt` when `rx_los`=0, and it ignores all framing-error strobes.
- R8: On a cycle with `sec_tick`=1, each holding register takes the count accumulated before that cycle. The counter restarts at 1 if its event occurs in the same cycle, and at 0 otherwise.
- R9: The holding outputs stay unchanged in every cycle without a tick.
- R10: Each counter stops at its all-ones value instead of wrapping: 65535 for the line counter, and 2^PATH_W-1 and 2^OOS_W-1 for the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second boundary strobe |
| esf_mode | input | 1 | 1 = extended superframe, 0 = superframe |
| fs_incl | input | 1 | In SF mode, also count Fs bit errors |
| oos_sel | input | 1 | 0 = framing-bit errors, 1 = multiframes out of sync |
| rx_los | input | 1 | Receive loss of sync |
| lcv_evt | input | 1 | Line code violation strobe |
| crc_err_evt | input | 1 | CRC6 code-word error strobe |
| ft_err_evt | input | 1 | Ft framing-bit error strobe |
| fs_err_evt | input | 1 | Fs framing-bit error strobe |
| fps_err_evt | input | 1 | FPS framing-bit error strobe |
| mf_evt | input | 1 | Multiframe boundary strobe |
| lcv_hold_hi | output | 8 | Held line count, upper byte |
| lcv_hold_lo | output | 8 | Held line count, lower byte |
| path_hold | output | PATH_W | Held path count |
| oos_hold | output | OOS_W | Held out-of-sync count |

## Verification
The bench builds the block with its default widths: 16 bits for the line counter and 12 bits each for the path and out-of-sync counters. These widths are small enough that a single run of about seventy thousand back-to-back strobes drives all three counters to their all-ones limits within the cycle budget, so saturation is checked at the real sizes. The bench also steps the mode and select bits through each routing combination. It crosses a tick with a same-cycle event to check the restart value.

// File: rtl/t1pc_pkg.sv
package t1pc_pkg;

    localparam int LINE_CNT_W = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic {
        FRM_SF  = 1'b0,
        FRM_ESF = 1'b1
    } frame_mode_e;

    typedef enum logic {
        OOS_SRC_FBIT  = 1'b0,
        OOS_SRC_MFOOS = 1'b1
    } oos_src_e;

    typedef struct packed {
        logic line;
        logic path;
        logic oos;
    } cnt_evt_t;

endpackage

// File: rtl/t1pc_evt_route.sv
module t1pc_evt_route
    import t1pc_pkg::*;
(
    input  logic     esf_mode,
    input  logic     fs_incl,
    input  logic     oos_sel,
    input  logic     rx_los,
    input  logic     lcv_evt,
    input  logic     crc_err_evt,
    input  logic     ft_err_evt,
    input  logic     fs_err_evt,
    input  logic     fps_err_evt,
    input  logic     mf_evt,
    output cnt_evt_t evt
);

    frame_mode_e mode;
    oos_src_e    src;
    logic        sf_fbit;
    logic        fbit_err;
    logic        path_raw;

    assign mode    = frame_mode_e'(esf_mode);
    assign src     = oos_src_e'(oos_sel);
    assign sf_fbit = ft_err_evt | (fs_incl & fs_err_evt);

    // Framing-bit error and raw path event depend on the framing mode
    always_comb begin
        unique case (mode)
            FRM_ESF: begin
                fbit_err = fps_err_evt;
                path_raw = crc_err_evt;
            end
            FRM_SF: begin
                fbit_err = sf_fbit;
                path_raw = sf_fbit;
            end
            default: begin
                fbit_err = 1'b0;
                path_raw = 1'b0;
            end
        endcase
    end

    always_comb begin
        evt.line = lcv_evt;
        evt.path = path_raw & ~rx_los;
        unique case (src)
            OOS_SRC_FBIT:  evt.oos = fbit_err;
            OOS_SRC_MFOOS: evt.oos = mf_evt & rx_los;
            default:       evt.oos = 1'b0;
        endcase
    end

endmodule

// File: rtl/t1pc_sat_cnt.sv
module t1pc_sat_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] hold
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic at_max;
    assign at_max = (cnt == CNT_MAX);

    // Snapshot and restart share one edge; a same-cycle event seeds the new period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= '0;
        end else if (tick) begin
            hold <= cnt;
            cnt  <= inc ? CNT_ONE : '0;
        end else if (inc && !at_max) begin
            cnt  <= cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/t1_perf_counters.sv
module t1_perf_counters
    import t1pc_pkg::*;
#(
    parameter int PATH_W = 12,
    parameter int OOS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              esf_mode,
    input  logic              fs_incl,
    input  logic              oos_sel,
    input  logic              rx_los,
    input  logic              lcv_evt,
    input  logic              crc_err_evt,
    input  logic              ft_err_evt,
    input  logic              fs_err_evt,
    input  logic              fps_err_evt,
    input  logic              mf_evt,
    output logic [BYTE_W-1:0] lcv_hold_hi,
    output logic [BYTE_W-1:0] lcv_hold_lo,
    output logic [PATH_W-1:0] path_hold,
    output logic [OOS_W-1:0]  oos_hold
);

    cnt_evt_t              evt;
    logic [LINE_CNT_W-1:0] lcv_cnt;
    logic [LINE_CNT_W-1:0] lcv_hold;
    logic [PATH_W-1:0]     path_cnt;
    logic [OOS_W-1:0]      oos_cnt;

    t1pc_evt_route u_route (
        .esf_mode    (esf_mode),
        .fs_incl     (fs_incl),
        .oos_sel     (oos_sel),
        .rx_los      (rx_los),
        .lcv_evt     (lcv_evt),
        .crc_err_evt (crc_err_evt),
        .ft_err_evt  (ft_err_evt),
        .fs_err_evt  (fs_err_evt),
        .fps_err_evt (fps_err_evt),
        .mf_evt      (mf_evt),
        .evt         (evt)
    );

    t1pc_sat_cnt #(.W(LINE_CNT_W)) u_line (
        .clk (clk), .rst_n (rst_n), .tick (sec_tick), .inc (evt.line),
        .cnt (lcv_cnt), .hold (lcv_hold)
    );

    t1pc_sat_cnt #(.W(PATH_W)) u_path (
        .clk (clk), .rst_n (rst_n), .tick (sec_tick), .inc (evt.path),
        .cnt (path_cnt), .hold (path_hold)
    );

    t1pc_sat_cnt #(.W(OOS_W)) u_oos (
        .clk (clk), .rst_n (rst_n), .tick (sec_tick), .inc (evt.oos),
        .cnt (oos_cnt), .hold (oos_hold)
    );

    assign lcv_hold_hi = lcv_hold[LINE_CNT_W-1 -: BYTE_W];
    assign lcv_hold_lo = lcv_hold[BYTE_W-1:0];

endmodule

// File: rtl/t1pc_checker.sv
module t1pc_checker #(
    parameter int PATH_W = 12,
    parameter int OOS_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              esf_mode,
    input logic              oos_sel,
    input logic              rx_los,
    input logic              crc_err_evt,
    input logic [15:0]       lcv_cnt,
    input logic [PATH_W-1:0] path_cnt,
    input logic [OOS_W-1:0]  oos_cnt,
    input logic [7:0]        lcv_hold_hi,
    input logic [7:0]        lcv_hold_lo,
    input logic [PATH_W-1:0] path_hold,
    input logic [OOS_W-1:0]  oos_hold
);

    p_hold_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> ({lcv_hold_hi, lcv_hold_lo} == $past(lcv_cnt))
                     && (path_hold == $past(path_cnt)) && (oos_hold == $past(oos_cnt)));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (lcv_cnt <= 16'd1) && (path_cnt <= 1) && (oos_cnt <= 1));

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable({lcv_hold_hi, lcv_hold_lo}) && $stable(path_hold) && $stable(oos_hold));

    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> (lcv_cnt == $past(lcv_cnt)) || (lcv_cnt == $past(lcv_cnt) + 16'd1));

    p_esf_crc_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        esf_mode && !crc_err_evt && !sec_tick |=> $stable(path_cnt));

    p_los_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_los && !sec_tick |=> $stable(path_cnt));

    p_mf_needs_los_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oos_sel && !rx_los && !sec_tick |=> $stable(oos_cnt));

    p_line_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lcv_cnt == 16'hFFFF) && !sec_tick |=> lcv_cnt == 16'hFFFF);

    p_path_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (path_cnt == '1) && !sec_tick |=> path_cnt == '1);

endmodule

bind t1_perf_counters t1pc_checker #(.PATH_W(PATH_W), .OOS_W(OOS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .esf_mode    (esf_mode),
    .oos_sel     (oos_sel),
    .rx_los      (rx_los),
    .crc_err_evt (crc_err_evt),
    .lcv_cnt     (lcv_cnt),
    .path_cnt    (path_cnt),
    .oos_cnt     (oos_cnt),
    .lcv_hold_hi (lcv_hold_hi),
    .lcv_hold_lo (lcv_hold_lo),
    .path_hold   (path_hold),
    .oos_hold    (oos_hold)
);

// File: tb/t1_perf_counters_test.sv
`timescale 1ns/1ps
module t1_perf_counters_test;

    localparam int PW = 12;
    localparam int OW = 12;
    localparam int LMAX = 65535;
    localparam int PMAX = (1 << PW) - 1;
    localparam int OMAX = (1 << OW) - 1;

    typedef struct {
        string req;
        int    lcv;
        int    path;
        int    oos;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 0, esf_mode = 0, fs_incl = 0, oos_sel = 0, rx_los = 0;
    logic lcv_evt = 0, crc_err_evt = 0, ft_err_evt = 0, fs_err_evt = 0;
    logic fps_err_evt = 0, mf_evt = 0;
    logic [7:0]    lcv_hold_hi, lcv_hold_lo;
    logic [PW-1:0] path_hold;
    logic [OW-1:0] oos_hold;

    int n_tests = 0;
    int n_fail = 0;
    int m_lcv = 0, m_path = 0, m_oos = 0;
    string cur_req = "R1";
    exp_t  sb_q[$];
    exp_t  last_exp;
    bit    done = 0;

    always #5 clk = ~clk;

    t1_perf_counters #(.PATH_W(PW), .OOS_W(OW)) uut (
        .clk (clk), .rst_n (rst_n), .sec_tick (sec_tick),
        .esf_mode (esf_mode), .fs_incl (fs_incl), .oos_sel (oos_sel),
        .rx_los (rx_los), .lcv_evt (lcv_evt), .crc_err_evt (crc_err_evt),
        .ft_err_evt (ft_err_evt), .fs_err_evt (fs_err_evt),
        .fps_err_evt (fps_err_evt), .mf_evt (mf_evt),
        .lcv_hold_hi (lcv_hold_hi), .lcv_hold_lo (lcv_hold_lo),
        .path_hold (path_hold), .oos_hold (oos_hold)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_holds(input exp_t e);
        check(e.req, "lcv_hold_hi", int'(lcv_hold_hi), e.lcv >> 8);
        check(e.req, "lcv_hold_lo", int'(lcv_hold_lo), e.lcv & 255);
        check(e.req, "path_hold", int'(path_hold), e.path);
        check(e.req, "oos_hold", int'(oos_hold), e.oos);
    endtask

    // Driver: one cycle of strobes, model updated from the requirements
    task automatic step(input bit l, c, ft, fs, fps, mf, tk);
        bit sf_f, p_hit, o_hit;
        exp_t e;
        lcv_evt = l; crc_err_evt = c; ft_err_evt = ft; fs_err_evt = fs;
        fps_err_evt = fps; mf_evt = mf; sec_tick = tk;
        sf_f  = ft | (fs_incl & fs);
        p_hit = !rx_los && (esf_mode ? c : sf_f);
        o_hit = oos_sel ? (mf & rx_los) : (esf_mode ? fps : sf_f);
        if (tk) begin
            e.req = cur_req; e.lcv = m_lcv; e.path = m_path; e.oos = m_oos;
            sb_q.push_back(e);
            last_exp = e;
            m_lcv = int'(l); m_path = int'(p_hit); m_oos = int'(o_hit);
        end else begin
            if (l && m_lcv < LMAX) m_lcv++;
            if (p_hit && m_path < PMAX) m_path++;
            if (o_hit && m_oos < OMAX) m_oos++;
        end
        @(negedge clk);
        lcv_evt = 0; crc_err_evt = 0; ft_err_evt = 0; fs_err_evt = 0;
        fps_err_evt = 0; mf_evt = 0; sec_tick = 0;
    endtask

    task automatic tick();
        step(0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
    endtask

    // Monitor: pops expected snapshot after each tick edge
    always @(posedge clk) begin
        if (rst_n && sec_tick) begin
            #1;
            if (sb_q.size() == 0) begin
                check("R8", "scoreboard empty", 0, 1);
            end else begin
                check_holds(sb_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check("R1", "lcv_hold_hi", int'(lcv_hold_hi), 0);
        check("R1", "lcv_hold_lo", int'(lcv_hold_lo), 0);
        check("R1", "path_hold", int'(path_hold), 0);
        check("R1", "oos_hold", int'(oos_hold), 0);
        tick();

        // R2: line counter and byte split (300 -> hi 1, lo 44)
        cur_req = "R2";
        repeat (5) step(1, 0, 0, 0, 0, 0, 0);
        tick();
        repeat (300) step(1, 0, 0, 0, 0, 0, 0);
        tick();

        // R3 / R6: ESF mode, path on CRC only, oos on FPS
        cur_req = "R3";
        esf_mode = 1; fs_incl = 1; oos_sel = 0;
        repeat (3) step(0, 1, 0, 0, 0, 0, 0);
        repeat (2) step(0, 0, 1, 1, 0, 0, 0);
        repeat (4) step(0, 0, 0, 0, 1, 0, 0);
        tick();

        // R4 / R6: SF mode with and without Fs inclusion
        cur_req = "R4";
        esf_mode = 0; fs_incl = 0;
        repeat (2) step(0, 0, 1, 0, 0, 0, 0);
        repeat (3) step(0, 1, 0, 1, 1, 0, 0);
        tick();
        fs_incl = 1;
        step(0, 0, 1, 1, 0, 0, 0);
        repeat (2) step(0, 0, 0, 1, 0, 0, 0);
        tick();

        // R5 / R6: loss of sync gates path, framing-bit oos still counts
        cur_req = "R5";
        esf_mode = 1; rx_los = 1;
        repeat (4) step(1, 1, 0, 0, 0, 0, 0);
        repeat (2) step(0, 0, 0, 0, 1, 0, 0);
        tick();

        // R7: multiframes out of sync
        cur_req = "R7";
        oos_sel = 1;
        repeat (3) step(0, 0, 0, 0, 0, 1, 0);
        rx_los = 0;
        repeat (2) step(0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0, 0);
        tick();

        // R8: same-cycle event on tick seeds the new period
        cur_req = "R8";
        oos_sel = 0;
        repeat (6) step(1, 1, 0, 0, 1, 0, 0);
        step(1, 1, 0, 0, 1, 0, 1);
        @(negedge clk);
        // R9: holds unchanged while events accumulate
        repeat (9) step(1, 1, 0, 0, 1, 0, 0);
        @(negedge clk);
        check_holds('{req: "R9", lcv: last_exp.lcv, path: last_exp.path, oos: last_exp.oos});
        cur_req = "R8";
        tick();
        tick();

        // R10: saturation of all three counters
        cur_req = "R10";
        repeat (LMAX + 5) step(1, 1, 0, 0, 1, 0, 0);
        tick();

        repeat (3) @(negedge clk);
        check("R8", "scoreboard drained", sb_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule